// File: doc/BRIEF.md
# Split-Read 64-bit Cycle Counter

This block is a free-running 64-bit cycle counter. A 32-bit register port reads it one half at a time. Software starts the counter through a control register. To take a 64-bit sample, software reads the low word, then the high word, then the control register. The top bit of the control word says whether the two halves belong to the same count value. If that bit is clear, software repeats the three reads.

The high half is never captured at the time of the low read. Instead, a small tracker watches what happens between the two reads. Two events break a pair:

- a carry out of the low half into the high half;
- a pulse on the interrupt-taken input, which the core raises when it enters an interrupt or exception handler.

Either event marks the pair as torn, and the control register reports it.

The register port has one word address (`regAddr`) and single-cycle read and write strobes. Read data is combinational in the cycle of the read strobe. The control register sits at the `BASE_ADDR` parameter, and the low and high words sit at the next two addresses. With the default `BASE_ADDR` these are 0x103, 0x104 and 0x105. The word width is the `DATA_W` parameter (32 by default), and the counter is twice that width.

Top module: `splitcnt_top`

## Requirements
- R1: After reset, the counter is zero, the enable is clear, and a control read returns all zeros.
- R2: A write to the control address (0x103) loads the enable from write-data bit 0. A control read returns the enable in bit 0, the pair status in bit 31 (the top bit of the word), and zeros in all other bits.
- R3: While the enable is set, the counter adds one on every clock edge, starting at the edge after the enabling write. It wraps at 2^64.
- R4: While the enable is clear, the counter holds its value.
- R5: In the cycle of the read strobe, a read of the low address (0x104) returns counter bits 31:0 and a read of the high address (0x105) returns counter bits 63:32.
- R6: The status bit reads 1 only if three things hold. A low read came first. A high read came after it. No control read has occurred since that low read.
- R7: A carry into the upper half clears the status. This applies to a carry on any edge from the low-read edge itself up to, but not including, the high-read edge. A carry on the high-read edge does not clear it.
- R8: An interrupt-taken pulse clears the status. This applies to a pulse in any cycle from the low-read cycle up to, but not including, the high-read cycle. A pulse after the high read has no effect.
- R9: A control read disarms the tracker, so a second control read with no new low read returns status 0.
- R10: A high read with no arming low read before it leaves the status at 0.
- R11: Reads of addresses outside the three registers return 0. Writes to the low or high address do not change the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | ADDR_W | Register word address |
| regRdEn | input | 1 | Read strobe, one cycle per read |
| regWrEn | input | 1 | Write strobe, one cycle per write |
| regWdata | input | DATA_W | Write data |
| irqTaken | input | 1 | Pulses when the core enters an interrupt or exception |
| regRdata | output | DATA_W | Read data, valid in the cycle of the read strobe |

## Verification
A tracker stuck in the wrong state shows up at the very next control read. The status bit comes back set for a pair that should be torn, or clear for a clean pair. The bench therefore places low reads exactly on and just before the carry edge, so that an off-by-one in the tear window flips the status within three cycles. An enable or increment fault shows up as a low-word value that differs from the bench's cycle count on the first read after it occurs.

// File: rtl/splitcnt_pkg.sv
package splitcnt_pkg;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_LOW,
    SEL_HIGH
  } regSel_t;

  // strobes from control to datapath, one decoded access per cycle
  typedef struct packed {
    logic    lowRd;
    logic    highRd;
    logic    ctrlRd;
    logic    ctrlWr;
    regSel_t rdSel;
  } strobes_t;

  typedef enum logic [1:0] {
    TRK_IDLE,
    TRK_ARMED,
    TRK_PAIRED
  } trkState_t;

endpackage

// File: rtl/splitcnt_ctrl.sv
module splitcnt_ctrl
  import splitcnt_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h103
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regRdEn,
  input  logic              regWrEn,
  input  logic              irqTaken,
  input  logic              carryNext,
  output strobes_t          strobes,
  output logic              pairOk
);

  localparam logic [ADDR_W-1:0] CTRL_ADDR = BASE_ADDR;
  localparam logic [ADDR_W-1:0] LOW_ADDR  = BASE_ADDR + ADDR_W'(1);
  localparam logic [ADDR_W-1:0] HIGH_ADDR = BASE_ADDR + ADDR_W'(2);

  trkState_t trkState;
  logic      torn;
  logic      tearEvent;

  always_comb begin
    strobes = '0;
    strobes.rdSel = SEL_NONE;
    if (regRdEn) begin
      unique case (regAddr)
        CTRL_ADDR: begin strobes.ctrlRd = 1'b1; strobes.rdSel = SEL_CTRL; end
        LOW_ADDR:  begin strobes.lowRd  = 1'b1; strobes.rdSel = SEL_LOW;  end
        HIGH_ADDR: begin strobes.highRd = 1'b1; strobes.rdSel = SEL_HIGH; end
        default:   strobes.rdSel = SEL_NONE;
      endcase
    end
    strobes.ctrlWr = regWrEn && (regAddr == CTRL_ADDR);
  end

  assign tearEvent = carryNext | irqTaken;

  // the tear window runs from the low-read edge until just before the high read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trkState <= TRK_IDLE;
      torn     <= 1'b0;
    end else if (strobes.lowRd) begin
      trkState <= TRK_ARMED;
      torn     <= tearEvent;
    end else if (strobes.ctrlRd) begin
      trkState <= TRK_IDLE;
      torn     <= 1'b0;
    end else if (trkState == TRK_ARMED) begin
      if (strobes.highRd) trkState <= TRK_PAIRED;
      else if (tearEvent) torn <= 1'b1;
    end
  end

  assign pairOk = (trkState == TRK_PAIRED) && !torn;

endmodule

// File: rtl/splitcnt_datapath.sv
module splitcnt_datapath
  import splitcnt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobes_t            strobes,
  input  logic                enBit,
  input  logic                pairOk,
  output logic [DATA_W-1:0]   regRdata,
  output logic                carryNext,
  output logic                enabled,
  output logic [2*DATA_W-1:0] cntValue
);

  localparam int CNT_W      = 2 * DATA_W;
  localparam int STATUS_BIT = DATA_W - 1;

  logic [DATA_W-1:0] cntLow;
  logic [DATA_W-1:0] cntHigh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enabled <= 1'b0;
    else if (strobes.ctrlWr) enabled <= enBit;
  end

  assign carryNext = enabled && (&cntLow);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntLow  <= '0;
      cntHigh <= '0;
    end else if (enabled) begin
      cntLow <= cntLow + DATA_W'(1);
      if (carryNext) cntHigh <= cntHigh + DATA_W'(1);
    end
  end

  assign cntValue = CNT_W'({cntHigh, cntLow});

  always_comb begin
    regRdata = '0;
    unique case (strobes.rdSel)
      SEL_CTRL: begin
        regRdata[0]          = enabled;
        regRdata[STATUS_BIT] = pairOk;
      end
      SEL_LOW:  regRdata = cntLow;
      SEL_HIGH: regRdata = cntHigh;
      default:  regRdata = '0;
    endcase
  end

endmodule

// File: rtl/splitcnt_top.sv
module splitcnt_top
  import splitcnt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h103
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regRdEn,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              irqTaken,
  output logic [DATA_W-1:0] regRdata
);

  localparam int CNT_W = 2 * DATA_W;

  strobes_t         strobes;
  logic             pairOk;
  logic             carryNext;
  logic             enabled;
  logic [CNT_W-1:0] cntValue;

  splitcnt_ctrl #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regRdEn   (regRdEn),
    .regWrEn   (regWrEn),
    .irqTaken  (irqTaken),
    .carryNext (carryNext),
    .strobes   (strobes),
    .pairOk    (pairOk)
  );

  splitcnt_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .enBit     (regWdata[0]),
    .pairOk    (pairOk),
    .regRdata  (regRdata),
    .carryNext (carryNext),
    .enabled   (enabled),
    .cntValue  (cntValue)
  );

endmodule

// File: rtl/splitcnt_checker.sv
module splitcnt_checker #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h103
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   regAddr,
  input logic                regRdEn,
  input logic                regWrEn,
  input logic [DATA_W-1:0]   regWdata,
  input logic [DATA_W-1:0]   regRdata,
  input logic                enabled,
  input logic                pairOk,
  input logic [2*DATA_W-1:0] cntValue
);

  localparam int CNT_W = 2 * DATA_W;
  localparam logic [ADDR_W-1:0] LOW_ADDR = BASE_ADDR + ADDR_W'(1);

  // R2: control write loads the enable
  assert_enable_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == BASE_ADDR) |=> (enabled == $past(regWdata[0])));

  // R3: counting by one while enabled
  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    enabled |=> (cntValue == $past(cntValue) + {{(CNT_W-1){1'b0}}, 1'b1}));

  // R4: hold while disabled
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !enabled |=> $stable(cntValue));

  // R6: a fresh low read needs a later high read before status can be good
  assert_low_rearms_R6: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == LOW_ADDR) |=> !pairOk);

  // R9: a control read disarms
  assert_ctrl_disarm_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == BASE_ADDR) |=> !pairOk);

  // R6: status bit is never reported good for a bad pair
  assert_status_out_R6: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == BASE_ADDR && !pairOk) |-> !regRdata[DATA_W-1]);

endmodule

bind splitcnt_top splitcnt_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regAddr  (regAddr),
  .regRdEn  (regRdEn),
  .regWrEn  (regWrEn),
  .regWdata (regWdata),
  .regRdata (regRdata),
  .enabled  (enabled),
  .pairOk   (pairOk),
  .cntValue (cntValue)
);

// File: tb/splitcnt_top_test.sv
`timescale 1ns/1ps
module splitcnt_top_test;

  localparam int DW = 8;
  localparam int AW = 12;
  localparam logic [AW-1:0] A_CTRL = 12'h103;
  localparam logic [AW-1:0] A_LOW  = 12'h104;
  localparam logic [AW-1:0] A_HIGH = 12'h105;
  localparam logic [AW-1:0] A_NONE = 12'h106;

  // {sequence kind[2:0], expected status} ; kinds:
  // 0 L,H,C  1 L,irq,H,C  2 H,C  3 L,C  4 L,H,irq,C
  // 5 L,H,C,C(second checked)  6 L,idle,H,C  7 L+irq,H,C
  localparam int NVEC = 8;
  localparam logic [3:0] VEC [NVEC] = '{
    {3'd0, 1'b1}, {3'd1, 1'b0}, {3'd2, 1'b0}, {3'd3, 1'b0},
    {3'd4, 1'b1}, {3'd5, 1'b0}, {3'd6, 1'b1}, {3'd7, 1'b0}
  };

  logic clk = 0;
  logic rstN = 0;
  logic [AW-1:0] addr = '0;
  logic rdEn = 0, wrEn = 0, irq = 0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;

  int nTests = 0;
  int nFail = 0;
  logic done = 0;

  logic [2*DW-1:0] mCnt;
  logic mEn;

  always #2.5 clk = ~clk;

  splitcnt_top #(.DATA_W(DW), .ADDR_W(AW), .BASE_ADDR(A_CTRL)) uut (
    .clk(clk), .rstN(rstN), .regAddr(addr), .regRdEn(rdEn), .regWrEn(wrEn),
    .regWdata(wdata), .irqTaken(irq), .regRdata(rdata)
  );

  // reference count from R1, R3, R4
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt <= '0;
      mEn  <= 1'b0;
    end else begin
      if (mEn) mCnt <= mCnt + 1'b1;
      if (wrEn && addr == A_CTRL) mEn <= wdata[0];
    end
  end

  task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    nTests++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  // call at a falling edge; drives one access for one cycle
  task automatic issue(input logic [AW-1:0] a, input logic r, input logic w,
                       input logic [DW-1:0] d, input logic i, output logic [DW-1:0] q);
    addr = a; rdEn = r; wrEn = w; wdata = d; irq = i;
    #1 q = rdata;
    @(posedge clk);
    #1 addr = '0; rdEn = 0; wrEn = 0; wdata = '0; irq = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] q);
    @(negedge clk);
    issue(a, 1'b1, 1'b0, '0, 1'b0, q);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [DW-1:0] q;
    @(negedge clk);
    issue(a, 1'b0, 1'b1, d, 1'b0, q);
  endtask

  task automatic idle(input logic i);
    logic [DW-1:0] q;
    @(negedge clk);
    issue(A_NONE, 1'b0, 1'b0, '0, i, q);
  endtask

  task automatic rdLowChk(input string req);
    logic [DW-1:0] q, e;
    @(negedge clk);
    e = mCnt[DW-1:0];
    issue(A_LOW, 1'b1, 1'b0, '0, 1'b0, q);
    check(req, q, e);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nFail++;
      nTests++;
      $display("FAIL watchdog: run did not end");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] q, e, hiExp;
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    // R1 reset state
    rd(A_CTRL, q); check("R1 ctrl after reset", q, 8'h00);
    rd(A_LOW, q);  check("R1 low after reset", q, 8'h00);
    rd(A_HIGH, q); check("R1 high after reset", q, 8'h00);
    repeat (5) idle(1'b0);
    rd(A_LOW, q);  check("R4 disabled counter holds", q, 8'h00);

    // R2 enable
    wr(A_CTRL, 8'h01);
    rd(A_CTRL, q); check("R2 enable readback", q, 8'h01);
    repeat (3) idle(1'b0);
    rdLowChk("R3 low tracks cycles");
    @(negedge clk); e = mCnt[2*DW-1:DW]; issue(A_HIGH, 1, 0, '0, 0, q);
    check("R5 high word value", q, e);

    // vector walk for R6 R8 R9 R10
    for (int v = 0; v < NVEC; v++) begin
      logic [2:0] kind;
      logic expS;
      kind = VEC[v][3:1];
      expS = VEC[v][0];
      while (mCnt[DW-1:0] >= 8'd200) @(negedge clk);
      case (kind)
        3'd0: begin rd(A_LOW, q); rd(A_HIGH, q); end
        3'd1: begin rd(A_LOW, q); idle(1'b1); rd(A_HIGH, q); end
        3'd2: begin rd(A_HIGH, q); end
        3'd3: begin rd(A_LOW, q); end
        3'd4: begin rd(A_LOW, q); rd(A_HIGH, q); idle(1'b1); end
        3'd5: begin rd(A_LOW, q); rd(A_HIGH, q); rd(A_CTRL, q); end
        3'd6: begin rd(A_LOW, q); idle(1'b0); rd(A_HIGH, q); end
        default: begin
          @(negedge clk); issue(A_LOW, 1, 0, '0, 1'b1, q);
          rd(A_HIGH, q);
        end
      endcase
      rd(A_CTRL, q);
      check($sformatf("R6/R8/R9/R10 vector %0d", v), q, {expS, 6'b0, 1'b1});
    end

    // R7 carry on high-read edge does not tear
    while (mCnt[DW-1:0] != 8'hFD) @(negedge clk);
    @(negedge clk); e = mCnt[DW-1:0]; issue(A_LOW, 1, 0, '0, 0, q);
    check("R5 low at FE", q, e);
    @(negedge clk); hiExp = mCnt[2*DW-1:DW]; issue(A_HIGH, 1, 0, '0, 0, q);
    check("R7 high before carry", q, hiExp);
    rd(A_CTRL, q); check("R7 carry at high edge keeps pair", q, 8'h81);

    // R7 carry on low-read edge tears
    while (mCnt[DW-1:0] != 8'hFE) @(negedge clk);
    @(negedge clk); issue(A_LOW, 1, 0, '0, 0, q);
    check("R5 low at FF", q, 8'hFF);
    rd(A_HIGH, q);
    rd(A_CTRL, q); check("R7 carry at low edge tears", q, 8'h01);

    // R7 carry in gap tears
    while (mCnt[DW-1:0] != 8'hFD) @(negedge clk);
    rd(A_LOW, q); idle(1'b0); rd(A_HIGH, q);
    rd(A_CTRL, q); check("R7 carry between reads tears", q, 8'h01);

    // R11 unmapped and ignored writes
    rd(A_NONE, q); check("R11 unmapped read", q, 8'h00);
    wr(A_LOW, 8'h55); wr(A_HIGH, 8'hAA);
    rdLowChk("R11 low write ignored");

    // R4 hold after disable
    wr(A_CTRL, 8'h00);
    rd(A_LOW, e);
    repeat (4) idle(1'b0);
    rd(A_LOW, q); check("R4 hold after disable", q, e);
    rd(A_CTRL, q); check("R2 disable readback", q, 8'h00);

    // R1 reset mid-run
    wr(A_CTRL, 8'h01);
    repeat (4) idle(1'b0);
    @(negedge clk); rstN = 0;
    @(negedge clk); rstN = 1;
    rd(A_CTRL, q); check("R1 ctrl after mid-run reset", q, 8'h00);
    rd(A_LOW, q);  check("R1 counter cleared", q, 8'h00);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule